// File: doc/BRIEF.md
# Multi-Mode Down Counter Channel

This block is a single channel of an interval timer. A 16-bit down counter advances on a counting-clock enable and drives one output line whose waveform depends on the selected mode. The six modes cover a terminal-count flag, a gate-triggered one-shot, a periodic rate pulse, a square wave, and two single-strobe variants. The gate input either pauses counting or, in the triggered modes, restarts counting on its rising edge.

A host loads a reload value and a mode with one strobe and reads the live count back at any time. The power-up gate state is a parameter, so the same block serves as a channel whose gate sits high out of reset or one whose gate sits low.

Top module: `timer_channel`

## Requirements
- R1: After reset and until the first load strobe, `out` is 0, `count` is 0 and no input changes either of them.
- R2: A reload value of 0 is counted as 65536. In mode 0 it raises `out` after exactly 65536 counting steps.
- R3: Mode 0 (`mode_sel`=0): after a load, `out` is 0. It rises on the step where the elapsed count reaches the reload value N and then stays high until the next load.
- R4: Mode 1 (`mode_sel`=1): `out` is 0 while fewer than N steps have elapsed since the last load or trigger, and 1 afterwards.
- R5: Mode 2 (`mode_sel`=2): the counter reloads itself every N steps. `out` is 1 exactly while the elapsed count is a non-zero multiple of N.
- R6: Mode 3 (`mode_sel`=3, N of at least 2): with p the elapsed count modulo N and H=(N+1)/2, `out` is 1 while p<H. The counter steps by two and reads 2H-2p in the high phase and 2N-2p in the low phase.
- R7: Modes 4 and 5 (`mode_sel`=4 or 5): `out` is 1 only while the elapsed count equals N, so it goes high once per load or trigger.
- R8: In modes 0, 2, 3 and 4 a step happens only on a clock with `cnt_en` and `gate` both high. In modes 1 and 5 the gate level does not affect stepping.
- R9: In modes 1, 2, 3 and 5 a rising edge of `gate` (high now, low on the previous clock) restarts the elapsed count at 0 from the reload value. In modes 0 and 4 a rising edge does not restart.
- R10: Mode codes 6 and 7 act as modes 2 and 3.
- R11: A load strobe takes priority over a trigger and a step in the same clock. Counting starts on the next enabled clock. In modes 0, 1, 4 and 5, `count` reads (N minus elapsed) modulo 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting-clock enable, one step per high clock |
| mode_sel | input | 3 | Mode code, taken on a load strobe |
| load_val | input | 16 | Reload value, 0 meaning 65536 |
| load_stb | input | 1 | Load strobe for mode and reload value |
| gate | input | 1 | Gate level |
| out | output | 1 | Channel output line |
| count | output | 16 | Current counter value for readback |

## Verification
The bench drives loads, gate edges, and gaps in the counting enable, and compares both outputs every clock against elapsed-count formulas.

It exercises the following corner cases, each with the failure it would expose:
- **Reload of zero.** A block that took 0 literally would raise `out` at once instead of after 65536 steps.
- **Odd square-wave periods.** A wrong rounding would shift the high/low split by one count or let the readback go odd.
- **Mode-2 pulse at load.** A pulse at load time instead of only at non-zero multiples would show a spurious high right after loading.
- **Gate edges in every mode.** A block that retriggered in mode 0 or 4, or paused a one-shot on a low gate, would drift from the model.
- **Load coinciding with a gate edge.** A wrong priority would show up here.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } mode_e;

  // codes 6 and 7 alias the periodic modes
  function automatic mode_e fold_mode(input logic [2:0] code);
    logic [2:0] m;
    m = (code > 3'd5) ? (code - 3'd4) : code;
    return mode_e'(m);
  endfunction

  function automatic logic gate_retriggers(input mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) ||
           (m == MD_HWSTROBE);
  endfunction

  function automatic logic gate_ignored(input mode_e m);
    return (m == MD_ONESHOT) || (m == MD_HWSTROBE);
  endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge #(
  parameter logic GATE_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= GATE_INIT;
    end else begin
      gate_q <= gate_i;
    end
  end

  assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/tmr_load_ctl.sv
module tmr_load_ctl
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16,
  localparam int EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [2:0]    mode_code_i,
  input  logic [CW-1:0] val_i,
  output logic          armed_o,
  output mode_e         mode_o,
  output logic [EW-1:0] reload_o,
  output mode_e         mode_eff_o,
  output logic [EW-1:0] reload_eff_o
);

  localparam logic [EW-1:0] FULL_RANGE = {1'b1, {CW{1'b0}}};

  logic          armed_q, armed_n;
  mode_e         mode_q, mode_n;
  logic [EW-1:0] reload_q, reload_n;
  logic [EW-1:0] val_ext;

  assign val_ext = (val_i == '0) ? FULL_RANGE : {1'b0, val_i};

  always_comb begin
    armed_n  = armed_q;
    mode_n   = mode_q;
    reload_n = reload_q;
    if (load_i) begin
      armed_n  = 1'b1;
      mode_n   = fold_mode(mode_code_i);
      reload_n = val_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      mode_q   <= MD_TERM;
      reload_q <= FULL_RANGE;
    end else begin
      armed_q  <= armed_n;
      mode_q   <= mode_n;
      reload_q <= reload_n;
    end
  end

  assign armed_o      = armed_q;
  assign mode_o       = mode_q;
  assign reload_o     = reload_q;
  assign mode_eff_o   = load_i ? fold_mode(mode_code_i) : mode_q;
  assign reload_eff_o = load_i ? val_ext : reload_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_chan_pkg::*;
#(
  parameter int CW = 16,
  localparam int EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          restart_i,
  input  logic          step_i,
  input  mode_e         mode_i,
  input  logic [EW-1:0] reload_i,
  output logic [EW-1:0] cnt_o,
  output logic          hit_o,
  output logic          hi_phase_o
);

  localparam logic [EW-1:0] ONE = EW'(1);
  localparam logic [EW-1:0] TWO = EW'(2);

  logic [EW-1:0] cnt_q, cnt_n;
  logic          phase_q, phase_n;
  logic [EW-1:0] sq_hi, sq_lo;
  logic          restart_any;

  // high half rounds up, low half rounds down; both stay even
  assign sq_hi = reload_i + EW'(reload_i[0]);
  assign sq_lo = reload_i - EW'(reload_i[0]);
  assign restart_any = load_i | restart_i;

  always_comb begin
    cnt_n   = cnt_q;
    phase_n = phase_q;
    if (restart_any) begin
      cnt_n   = (mode_i == MD_SQUARE) ? sq_hi : reload_i;
      phase_n = 1'b1;
    end else if (step_i) begin
      case (mode_i)
        MD_SQUARE: begin
          if (cnt_q <= TWO) begin
            phase_n = ~phase_q;
            cnt_n   = phase_q ? sq_lo : sq_hi;
          end else begin
            cnt_n = cnt_q - TWO;
          end
        end
        MD_RATE: begin
          cnt_n = (cnt_q == ONE) ? reload_i : (cnt_q - ONE);
        end
        default: begin
          cnt_n = cnt_q - ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= {1'b1, {CW{1'b0}}};
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
    end
  end

  assign cnt_o      = cnt_q;
  assign hi_phase_o = phase_q;
  assign hit_o      = step_i & ~restart_any & (cnt_q == ONE);

endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen
  import tmr_chan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart_i,
  input  logic  step_i,
  input  logic  hit_i,
  input  mode_e mode_i,
  input  logic  armed_i,
  input  logic  hi_phase_i,
  output logic  out_o
);

  logic flag_q, flag_n;
  logic fired_q, fired_n;

  always_comb begin
    flag_n  = flag_q;
    fired_n = fired_q;
    if (restart_i) begin
      flag_n  = 1'b0;
      fired_n = 1'b0;
    end else if (step_i) begin
      case (mode_i)
        MD_TERM, MD_ONESHOT: flag_n = flag_q | hit_i;
        MD_RATE:             flag_n = hit_i;
        MD_SWSTROBE, MD_HWSTROBE: begin
          flag_n  = hit_i & ~fired_q;
          fired_n = fired_q | hit_i;
        end
        default: flag_n = flag_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      fired_q <= fired_n;
    end
  end

  assign out_o = armed_i & ((mode_i == MD_SQUARE) ? hi_phase_i : flag_q);

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import tmr_chan_pkg::*;
#(
  parameter int   CW        = 16,
  parameter logic GATE_INIT = 1'b1,
  localparam int  EW        = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [2:0]    mode_sel,
  input  logic [CW-1:0] load_val,
  input  logic          load_stb,
  input  logic          gate,
  output logic          out,
  output logic [CW-1:0] count
);

  logic          armed_q;
  mode_e         mode_q, mode_eff;
  logic [EW-1:0] reload_q, reload_eff;
  logic [EW-1:0] cnt_q;
  logic          gate_rise, restart, step, hit, hi_phase;

  tmr_gate_edge #(.GATE_INIT(GATE_INIT)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  tmr_load_ctl #(.CW(CW)) u_load (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_stb),
    .mode_code_i  (mode_sel),
    .val_i        (load_val),
    .armed_o      (armed_q),
    .mode_o       (mode_q),
    .reload_o     (reload_q),
    .mode_eff_o   (mode_eff),
    .reload_eff_o (reload_eff)
  );

  // load outranks a trigger, a trigger outranks a step
  assign restart = armed_q & ~load_stb & gate_rise & gate_retriggers(mode_q);
  assign step    = armed_q & ~load_stb & ~restart & cnt_en &
                   (gate | gate_ignored(mode_q));

  tmr_count_core #(.CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_stb),
    .restart_i  (restart),
    .step_i     (step),
    .mode_i     (mode_eff),
    .reload_i   (reload_eff),
    .cnt_o      (cnt_q),
    .hit_o      (hit),
    .hi_phase_o (hi_phase)
  );

  tmr_out_gen u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart | load_stb),
    .step_i     (step),
    .hit_i      (hit),
    .mode_i     (mode_q),
    .armed_i    (armed_q),
    .hi_phase_i (hi_phase),
    .out_o      (out)
  );

  assign count = armed_q ? cnt_q[CW-1:0] : '0;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int  CW = 16,
  localparam int EW = CW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_stb,
  input logic [CW-1:0] load_val,
  input logic          gate,
  input logic          out,
  input logic [CW-1:0] count,
  input logic          armed_q,
  input mode_e         mode_q,
  input logic [EW-1:0] reload_q,
  input logic [EW-1:0] cnt_q
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (!out && count == '0));

  assert_zero_full_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_val == '0) |=> (reload_q[CW] && count == '0));

  assert_term_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_q == MD_TERM && out && !load_stb) |=> out);

  assert_rate_pulse_at_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_q == MD_RATE && out) |-> (cnt_q == reload_q));

  assert_square_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_q == MD_SQUARE) |-> (cnt_q[0] == 1'b0));

  assert_gate_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (mode_q == MD_TERM || mode_q == MD_SWSTROBE) && !gate && !load_stb)
    |=> $stable(count));

endmodule

bind timer_channel tmr_chan_chk #(.CW(CW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_stb (load_stb),
  .load_val (load_val),
  .gate     (gate),
  .out      (out),
  .count    (count),
  .armed_q  (armed_q),
  .mode_q   (mode_q),
  .reload_q (reload_q),
  .cnt_q    (cnt_q)
);

// File: tb/test_timer_channel.sv
module test_timer_channel;

  localparam int   CLK_PERIOD = 10;
  localparam logic GINIT      = 1'b0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] load_val = 16'd0;
  logic        load_stb = 1'b0;
  logic        gate = 1'b0;
  logic        out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // behavioural model state
  bit      m_armed;
  int      m_mode;
  longint  m_n;
  longint  m_e;
  bit      m_gprev;

  timer_channel #(.CW(16), .GATE_INIT(GINIT)) i_timer_channel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .mode_sel (mode_sel),
    .load_val (load_val),
    .load_stb (load_stb),
    .gate     (gate),
    .out      (out),
    .count    (count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit retrig(int m);
    return (m == 1) || (m == 2) || (m == 3) || (m == 5);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_mode = 0; m_n = 65536; m_e = 0; m_gprev = GINIT;
    end else begin
      if (load_stb) begin
        m_armed = 1;
        m_mode  = (mode_sel > 5) ? int'(mode_sel) - 4 : int'(mode_sel);
        m_n     = (load_val == 0) ? 65536 : longint'(load_val);
        m_e     = 0;
      end else if (m_armed) begin
        if (gate && !m_gprev && retrig(m_mode)) m_e = 0;
        else if (cnt_en && (m_mode == 1 || m_mode == 5 || gate)) m_e = m_e + 1;
      end
      m_gprev = gate;
    end
  end

  function automatic bit exp_out();
    longint p, h;
    if (!m_armed) return 0;
    p = m_e % m_n;
    h = (m_n + 1) / 2;
    case (m_mode)
      0, 1:    return m_e >= m_n;
      2:       return (m_e != 0) && (p == 0);
      3:       return p < h;
      default: return m_e == m_n;
    endcase
  endfunction

  function automatic logic [15:0] exp_count();
    longint p, h, v;
    if (!m_armed) return 16'd0;
    p = m_e % m_n;
    h = (m_n + 1) / 2;
    case (m_mode)
      2:       v = m_n - p;
      3:       v = (p < h) ? (2*h - 2*p) : (2*m_n - 2*p);
      default: v = m_n - m_e;
    endcase
    return v[15:0];
  endfunction

  task automatic check_bit(string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_tag, what, act, expv, $time);
    end
  endtask

  task automatic check_word(string what, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_tag, what, act, expv, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check_bit("out", out, exp_out());
      check_word("count", count, exp_count());
    end
  end

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      cnt_en = ((i % every) == 0);
      @(negedge clk);
    end
  endtask

  task automatic load(int m, int v);
    mode_sel = 3'(m);
    load_val = 16'(v);
    load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle before first load, inputs have no effect
    cur_tag = "R1";
    gate = 1'b1;
    run(3, 1);
    gate = 1'b0;
    run(2, 1);
    check_bit("idle out", out, 1'b0);
    check_word("idle count", count, 16'd0);

    // R3: terminal-count flag; R8 pause with gate low; R9 no restart in mode 0
    cur_tag = "R3";
    gate = 1'b1;
    load(0, 5);
    run(8, 1);
    cur_tag = "R8";
    load(0, 6);
    run(2, 1);
    gate = 1'b0;
    run(4, 1);
    gate = 1'b1;
    cur_tag = "R9";
    run(2, 1);
    gate = 1'b0;
    run(1, 1);
    gate = 1'b1;
    run(6, 1);

    // R4: one-shot counts with gate low, gate rise restarts
    cur_tag = "R4";
    gate = 1'b0;
    load(1, 4);
    run(3, 1);
    gate = 1'b1;
    run(7, 1);
    gate = 1'b0;
    run(1, 1);
    gate = 1'b1;
    run(6, 1);

    // R5: rate pulses, sparse enable, N=1, pause, restart
    cur_tag = "R5";
    load(2, 3);
    run(14, 2);
    load(2, 1);
    run(4, 1);
    gate = 1'b0;
    run(3, 1);
    gate = 1'b1;
    run(3, 1);
    load(2, 4);
    run(5, 1);
    gate = 1'b0;
    run(1, 1);
    cur_tag = "R9";
    gate = 1'b1;
    run(6, 1);

    // R6: square wave for odd and even periods, restart on gate rise
    cur_tag = "R6";
    load(3, 5);
    run(16, 1);
    load(3, 6);
    run(14, 1);
    load(3, 2);
    run(6, 1);
    load(3, 7);
    run(4, 1);
    gate = 1'b0;
    run(2, 1);
    gate = 1'b1;
    run(10, 1);

    // R7: single strobes in modes 4 and 5
    cur_tag = "R7";
    load(4, 3);
    run(8, 1);
    gate = 1'b0;
    load(5, 3);
    run(5, 1);
    gate = 1'b1;
    run(6, 1);

    // R10: codes 6 and 7 alias rate and square
    cur_tag = "R10";
    load(6, 4);
    run(10, 1);
    load(7, 5);
    run(12, 1);

    // R11: reload mid-count, and load in the same clock as a gate rise
    cur_tag = "R11";
    load(0, 10);
    run(4, 1);
    load(0, 3);
    run(5, 1);
    load(1, 6);
    run(2, 1);
    gate = 1'b0;
    run(1, 1);
    gate = 1'b1;
    cnt_en = 1'b1;
    load(1, 2);
    run(4, 1);

    // R2: zero reload means 65536 steps
    cur_tag = "R2";
    load(0, 0);
    run(65535, 1);
    check_bit("before full range", out, 1'b0);
    run(3, 1);
    check_bit("after full range", out, 1'b1);

    finish_run();
  end

endmodule